// File: doc/BRIEF.md
# Two-Phase Media Sanitization Sequencer

This controller wipes every physical block of a flash array once a wipe is requested. Blocks held in spare for wear leveling and blocks retired as bad are included. It runs in two steps. First comes a quick purge that erases each block index in turn. Then comes a longer overwrite protocol, picked by a configuration input, made of program passes with fixed data and a closing erase. Each step is called a phase.

The controller drives a block-operation port one command at a time and waits for a completion strobe before it moves on. It keeps a small persistent record, consisting of a pending bit, the phase and the protocol, through a register interface. If power fails during a wipe, the next power-up restarts the interrupted phase from block 0 without a new request. A cycle meter covers the purge step so that its time budget, of the order of ten seconds, can be checked against the clock rate.

Top module: `sanitize_seq`

## Requirements
- R1: After reset, with the persistent pending bit clear, `busy`, `cmd_start` and `nv_wr_en` are low and `err_count` is 0.
- R2: Phase 0, the purge, issues one erase (`cmd_prog`=0) to every block index 0 to NUM_BLOCKS-1 in ascending order. Spare and bad blocks are included, because every physical index is covered.
- R3: Phase 0 ends before any protocol pass starts. Pass k (phase k, k≥1) then visits blocks 0 to NUM_BLOCKS-1 in ascending order.
- R4: `proto_sel` selects the passes after the purge, where Z = program 0x00, O = program all-ones, P = program PATTERN (default 0xA5), and E = erase. The choices are 1: Z,O,E; 2: O,Z,P,E; 3: P,E; 4: Z,O,P,E; 5: Z,O,Z,O,P,E. Codes 0, 6 and 7 run the purge only. A program has `cmd_prog`=1 with the data on `cmd_data`.
- R5: Before the first command of each phase, one persistent write with pending=1 records the phase and the protocol. After the last block of the last phase, one write with pending=0 ends the wipe. A wipe makes exactly (passes+2) writes.
- R6: If the pending bit reads 1 at the first cycle after reset, the stored protocol resumes at the stored phase from block 0, with no request needed, and runs to the end.
- R7: Only one block operation is outstanding. `cmd_start` is a one-cycle pulse, and the next pulse comes only after `cmd_done`.
- R8: A `cmd_err` that comes with `cmd_done` increments the saturating `err_count`, and the sequence goes on with the next block. The count clears when a request is accepted.
- R9: `busy` is high from acceptance until the final persistent write. A request that arrives while busy is ignored.
- R10: `purge_cycles` clears on acceptance and counts every clock of phase 0. After a completion delay of D cycles per block, it equals 1+NUM_BLOCKS*(D+1). It then holds its value through the later phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| erase_req | input | 1 | Wipe request, sampled when idle |
| proto_sel | input | 3 | Overwrite protocol choice |
| nv_rd_pending | input | 1 | Persistent record: wipe pending |
| nv_rd_phase | input | 3 | Persistent record: phase |
| nv_rd_proto | input | 3 | Persistent record: protocol |
| nv_wr_en | output | 1 | Persistent record write strobe |
| nv_wr_pending | output | 1 | Pending bit to store |
| nv_wr_phase | output | 3 | Phase to store |
| nv_wr_proto | output | 3 | Protocol to store |
| cmd_start | output | 1 | One-cycle block operation start |
| cmd_prog | output | 1 | 0 erase, 1 program |
| cmd_block | output | $clog2(NUM_BLOCKS) | Physical block index |
| cmd_data | output | DATA_W | Program fill value |
| cmd_done | input | 1 | Operation complete strobe |
| cmd_err | input | 1 | Operation failed, valid with cmd_done |
| busy | output | 1 | Wipe in progress |
| err_count | output | ERR_W | Failed operations in this wipe |
| purge_cycles | output | CYC_W | Clocks spent in the purge phase |

## Verification
The assertions assume that the operation port raises `cmd_done` only while a command is outstanding, never in the cycle of `cmd_start`, and that `cmd_err` is only meaningful together with `cmd_done`. They also assume that the persistent record returns what was last written. The bench responder keeps to these rules. It answers each start a fixed number of cycles later with one strobe, and it keeps a record model that survives reset. The power-loss case is made by asserting reset partway through a pass.

// File: rtl/sanitize_pkg.sv
package sanitize_pkg;
  localparam int PROTO_W = 3;
  localparam int PHASE_W = 3;

  typedef enum logic [1:0] {PK_ERASE, PK_ZERO, PK_ONE, PK_PAT} pass_kind_e;

  typedef enum logic [2:0] {
    ST_BOOT, ST_IDLE, ST_NVW, ST_ISSUE, ST_WAIT, ST_CLEAR
  } seq_state_e;
endpackage

// File: rtl/sanitize_pass_table.sv
module sanitize_pass_table
  import sanitize_pkg::*;
(
  input  logic [PROTO_W-1:0] proto,
  input  logic [PHASE_W-1:0] phase,
  output pass_kind_e         kind,
  output logic [PHASE_W-1:0] npass
);
  always_comb begin
    case (proto)
      3'd1:    npass = 3'd3;
      3'd2:    npass = 3'd4;
      3'd3:    npass = 3'd2;
      3'd4:    npass = 3'd4;
      3'd5:    npass = 3'd6;
      default: npass = 3'd0;
    endcase
    kind = PK_ERASE;
    if (phase != 3'd0 && phase < npass) begin
      case (proto)
        3'd1: kind = (phase == 3'd1) ? PK_ZERO : PK_ONE;
        3'd2: case (phase)
                3'd1:    kind = PK_ONE;
                3'd2:    kind = PK_ZERO;
                default: kind = PK_PAT;
              endcase
        3'd3: kind = PK_PAT;
        3'd4: case (phase)
                3'd1:    kind = PK_ZERO;
                3'd2:    kind = PK_ONE;
                default: kind = PK_PAT;
              endcase
        3'd5: case (phase)
                3'd1, 3'd3: kind = PK_ZERO;
                3'd2, 3'd4: kind = PK_ONE;
                default:    kind = PK_PAT;
              endcase
        default: kind = PK_ERASE;
      endcase
    end
  end
endmodule

// File: rtl/sanitize_purge_meter.sv
module sanitize_purge_meter #(
  parameter int CYC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             tick,
  output logic [CYC_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clear)
      count <= '0;
    else if (tick && count != '1)
      count <= count + 1'b1;
  end
endmodule

// File: rtl/sanitize_seq.sv
module sanitize_seq
  import sanitize_pkg::*;
#(
  parameter int                NUM_BLOCKS = 16,
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-1:0] PATTERN    = 8'hA5,
  parameter int                CYC_W      = 32,
  parameter int                ERR_W      = 8,
  localparam int               BLK_W      = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               erase_req,
  input  logic [PROTO_W-1:0] proto_sel,
  input  logic               nv_rd_pending,
  input  logic [PHASE_W-1:0] nv_rd_phase,
  input  logic [PROTO_W-1:0] nv_rd_proto,
  output logic               nv_wr_en,
  output logic               nv_wr_pending,
  output logic [PHASE_W-1:0] nv_wr_phase,
  output logic [PROTO_W-1:0] nv_wr_proto,
  output logic               cmd_start,
  output logic               cmd_prog,
  output logic [BLK_W-1:0]   cmd_block,
  output logic [DATA_W-1:0]  cmd_data,
  input  logic               cmd_done,
  input  logic               cmd_err,
  output logic               busy,
  output logic [ERR_W-1:0]   err_count,
  output logic [CYC_W-1:0]   purge_cycles
);
  localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

  seq_state_e         state_q;
  logic [PROTO_W-1:0] proto_q;
  logic [PHASE_W-1:0] phase_q;
  logic [BLK_W-1:0]   blk_q;
  logic [ERR_W-1:0]   err_q;
  pass_kind_e         kind;
  logic [PHASE_W-1:0] npass;

  sanitize_pass_table u_table (
    .proto (proto_q),
    .phase (phase_q),
    .kind  (kind),
    .npass (npass)
  );

  sanitize_purge_meter #(.CYC_W(CYC_W)) u_meter (
    .clk   (clk),
    .rst   (rst),
    .clear (state_q == ST_IDLE && erase_req),
    .tick  (phase_q == '0 &&
            (state_q == ST_NVW || state_q == ST_ISSUE || state_q == ST_WAIT)),
    .count (purge_cycles)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_BOOT;
      proto_q <= '0;
      phase_q <= '0;
      blk_q   <= '0;
      err_q   <= '0;
    end else begin
      case (state_q)
        ST_BOOT: begin
          if (nv_rd_pending) begin
            proto_q <= nv_rd_proto;
            phase_q <= nv_rd_phase;
            state_q <= ST_NVW;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_IDLE: begin
          if (erase_req) begin
            proto_q <= proto_sel;
            phase_q <= '0;
            err_q   <= '0;
            state_q <= ST_NVW;
          end
        end
        ST_NVW: begin
          blk_q   <= '0;
          state_q <= (phase_q > npass) ? ST_CLEAR : ST_ISSUE;
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (cmd_done) begin
            if (cmd_err && err_q != '1)
              err_q <= err_q + 1'b1;
            if (blk_q == LAST_BLK) begin
              if (phase_q >= npass) begin
                state_q <= ST_CLEAR;
              end else begin
                phase_q <= phase_q + 1'b1;
                state_q <= ST_NVW;
              end
            end else begin
              blk_q   <= blk_q + 1'b1;
              state_q <= ST_ISSUE;
            end
          end
        end
        ST_CLEAR: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy          = (state_q != ST_IDLE) && (state_q != ST_BOOT);
  assign nv_wr_en      = (state_q == ST_NVW) || (state_q == ST_CLEAR);
  assign nv_wr_pending = (state_q == ST_NVW);
  assign nv_wr_phase   = phase_q;
  assign nv_wr_proto   = proto_q;
  assign cmd_start     = (state_q == ST_ISSUE);
  assign cmd_block     = blk_q;
  assign cmd_prog      = (kind != PK_ERASE);
  assign err_count     = err_q;

  always_comb begin
    case (kind)
      PK_ONE:  cmd_data = '1;
      PK_PAT:  cmd_data = PATTERN;
      default: cmd_data = '0;
    endcase
  end

  a_r7_single_op: assert property (@(posedge clk) disable iff (rst)
    cmd_start |=> !cmd_start);
  a_r2_block_range: assert property (@(posedge clk) disable iff (rst)
    cmd_start |-> cmd_block <= LAST_BLK);
  a_r5_record_first: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && cmd_block == '0) |-> $past(nv_wr_en && nv_wr_pending));
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !cmd_start);
  a_r8_err_monotonic: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> err_count >= $past(err_count));
  a_r10_meter_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && phase_q != '0 && $past(busy && phase_q != '0)) |-> $stable(purge_cycles));
endmodule

// File: tb/sanitize_seq_tb_top.sv
module sanitize_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB  = 16;
  localparam int DLY = 3;
  localparam logic [7:0] PAT = 8'hA5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic erase_req = 1'b0;
  logic [2:0] proto_sel = 3'd0;
  logic nv_pend = 1'b0;
  logic [2:0] nv_ph = 3'd0;
  logic [2:0] nv_pr = 3'd0;
  logic nv_wr_en, nv_wr_pending;
  logic [2:0] nv_wr_phase, nv_wr_proto;
  logic cmd_start, cmd_prog;
  logic [3:0] cmd_block;
  logic [7:0] cmd_data;
  logic cmd_done = 1'b0;
  logic cmd_err = 1'b0;
  logic busy;
  logic [7:0] err_count;
  logic [31:0] purge_cycles;

  int tests = 0;
  int fails = 0;
  int log_n = 0;
  logic log_prog [0:255];
  logic [3:0] log_blk [0:255];
  logic [7:0] log_dat [0:255];
  int nv_writes = 0;
  int nv_viol = 0;
  int cnt = 0;
  logic [3:0] cur_blk = '0;
  logic err_en = 1'b0;
  logic [3:0] err_blk = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sanitize_seq dut_i (
    .clk(clk), .rst(rst), .erase_req(erase_req), .proto_sel(proto_sel),
    .nv_rd_pending(nv_pend), .nv_rd_phase(nv_ph), .nv_rd_proto(nv_pr),
    .nv_wr_en(nv_wr_en), .nv_wr_pending(nv_wr_pending),
    .nv_wr_phase(nv_wr_phase), .nv_wr_proto(nv_wr_proto),
    .cmd_start(cmd_start), .cmd_prog(cmd_prog), .cmd_block(cmd_block),
    .cmd_data(cmd_data), .cmd_done(cmd_done), .cmd_err(cmd_err),
    .busy(busy), .err_count(err_count), .purge_cycles(purge_cycles)
  );

  // Block-operation responder and persistent record model (survives reset)
  always @(negedge clk) begin
    cmd_done = 1'b0;
    cmd_err  = 1'b0;
    if (rst) begin
      cnt = 0;
    end else begin
      if (cnt > 0) begin
        cnt = cnt - 1;
        if (cnt == 0) begin
          cmd_done = 1'b1;
          cmd_err  = err_en && (cur_blk == err_blk);
        end
      end
      if (cmd_start) begin
        if (log_n < 256) begin
          log_prog[log_n] = cmd_prog;
          log_blk[log_n]  = cmd_block;
          log_dat[log_n]  = cmd_data;
        end
        log_n = log_n + 1;
        if (!nv_pend) nv_viol = nv_viol + 1;
        cur_blk = cmd_block;
        cnt = DLY;
      end
      if (nv_wr_en) begin
        nv_pend = nv_wr_pending;
        nv_ph   = nv_wr_phase;
        nv_pr   = nv_wr_proto;
        nv_writes = nv_writes + 1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails = fails + 1;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic int exp_np(int p);
    case (p)
      1: return 3;
      2: return 4;
      3: return 2;
      4: return 4;
      5: return 6;
      default: return 0;
    endcase
  endfunction

  // 0 erase, 1 zeros, 2 ones, 3 pattern
  function automatic int exp_kind(int p, int ph);
    int z1 [5] = '{1, 2, 0, 0, 0};
    int z2 [5] = '{2, 1, 3, 0, 0};
    int z4 [5] = '{1, 2, 3, 0, 0};
    int z5 [5] = '{1, 2, 1, 2, 3};
    if (ph == 0 || ph >= exp_np(p)) return 0;
    case (p)
      1: return z1[ph-1];
      2: return z2[ph-1];
      3: return 3;
      4: return z4[ph-1];
      default: return z5[ph-1];
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_req(input int p);
    @(negedge clk);
    erase_req = 1'b1;
    proto_sel = 3'(p);
    @(negedge clk);
    erase_req = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (!busy && guard < 10) begin @(negedge clk); guard++; end
    guard = 0;
    while (busy && guard < 20000) begin @(negedge clk); guard++; end
  endtask

  task automatic clear_log();
    log_n = 0;
    nv_writes = 0;
    nv_viol = 0;
  endtask

  // compares the logged operations with phases first_ph..np of protocol p
  task automatic check_seq(input int p, input int first_ph, input string req);
    int np = exp_np(p);
    int n = NB * (np + 1 - first_ph);
    int bad = -1;
    check(log_n == n, req, "operation count", log_n, n);
    for (int k = 0; k < n && k < 256; k++) begin
      int ph = first_ph + k / NB;
      int kd = exp_kind(p, ph);
      logic ep = (kd != 0);
      logic [7:0] ed = (kd == 2) ? 8'hFF : (kd == 3) ? PAT : 8'h00;
      if (bad < 0 && (log_blk[k] != 4'(k % NB) || log_prog[k] != ep ||
                      (ep && log_dat[k] != ed)))
        bad = k;
    end
    check(bad < 0, req, "first mismatching operation index", bad, -1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);
    check(cmd_start == 1'b0, "R1", "cmd_start after reset", cmd_start, 0);
    check(nv_wr_en == 1'b0, "R1", "nv_wr_en after reset", nv_wr_en, 0);
    check(err_count == 8'd0, "R1", "err_count after reset", err_count, 0);
  endtask

  task automatic t_protocol(input int p, input string req);
    clear_log();
    pulse_req(p);
    wait_idle();
    check_seq(p, 0, req);
    check(nv_writes == exp_np(p) + 2, "R5", "record writes", nv_writes, exp_np(p) + 2);
    check(nv_viol == 0, "R5", "commands without pending record", nv_viol, 0);
    check(nv_pend == 1'b0, "R5", "pending after finish", nv_pend, 0);
  endtask

  task automatic t_meter();
    int guard = 0;
    logic [31:0] mid;
    clear_log();
    pulse_req(3);
    while (log_n < NB + 1 && guard < 5000) begin @(negedge clk); guard++; end
    mid = purge_cycles;
    check(mid == 32'(1 + NB * (DLY + 1)), "R10", "purge cycles", mid, 1 + NB * (DLY + 1));
    check(log_blk[NB-1] == 4'(NB - 1) && log_prog[NB] == 1'b1, "R3",
          "purge ends before first program", log_prog[NB], 1);
    wait_idle();
    check(purge_cycles == mid, "R10", "purge cycles held", purge_cycles, mid);
  endtask

  task automatic t_errors();
    clear_log();
    err_en = 1'b1;
    err_blk = 4'(NB - 1);
    pulse_req(1);
    wait_idle();
    err_en = 1'b0;
    check(err_count == 8'd4, "R8", "error count", err_count, 4);
    check(log_n == NB * 4, "R8", "sequence continued after errors", log_n, NB * 4);
    clear_log();
    pulse_req(0);
    wait_idle();
    check(err_count == 8'd0, "R8", "error count cleared on accept", err_count, 0);
  endtask

  task automatic t_busy_ignore();
    int guard = 0;
    clear_log();
    pulse_req(1);
    while (log_n < 5 && guard < 1000) begin @(negedge clk); guard++; end
    check(busy == 1'b1, "R9", "busy during wipe", busy, 1);
    pulse_req(5);
    wait_idle();
    check_seq(1, 0, "R9");
    check(busy == 1'b0, "R9", "busy after wipe", busy, 0);
  endtask

  task automatic t_resume();
    int guard = 0;
    clear_log();
    pulse_req(5);
    while (log_n < 2 * NB + 4 && guard < 5000) begin @(negedge clk); guard++; end
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(nv_pend == 1'b1 && nv_ph == 3'd2, "R6", "record phase at power loss", nv_ph, 2);
    clear_log();
    rst = 1'b0;
    wait_idle();
    check_seq(5, 2, "R6");
    check(nv_pend == 1'b0, "R6", "pending cleared after resume", nv_pend, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_protocol(0, "R2");
    t_protocol(1, "R4");
    t_protocol(2, "R4");
    t_protocol(4, "R4");
    t_protocol(5, "R3");
    t_protocol(7, "R4");
    t_meter();
    t_errors();
    t_busy_ignore();
    t_resume();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule